// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides whether a frame is kept. It looks only at the destination address, which is the first six bytes after the start-of-frame strobe. The frame is accepted when any of the enabled tests passes. The tests are: a match against either of two programmable station addresses, a match against the all-ones broadcast address, or a hit in a 64-entry group hash table.

The hash index has six bits. It is built while the bytes arrive, by XOR-ing the 48 address bits into a 6-bit accumulator. Address bit n, counted from byte 0 bit 0, lands on accumulator bit n mod 6. The hash test normally applies only to group addresses, which have byte 0 bit 0 set. A control bit extends it to individual addresses as well. The decision is presented as a one-cycle strobe on the cycle after the sixth address byte.

Configuration is written through a small select/data port. Each write goes into a shadow copy. That copy is loaded into the working set at each start of frame, so a write made in the middle of a frame never changes the decision for that frame.

Top module: `rx_da_filter`

## Requirements
- R1: After reset every configuration field is zero and `dec_vld`/`dec_accept` are low; with that configuration every frame is dropped, including broadcast.
- R2: Write selects are 0 = station address A low word, 1 = A high word, 2 = station address B low word, 3 = B high word, 4 = hash table low word, 5 = hash table high word, 6 = control. In a low word, bits [7:0] hold the first address byte on the wire and bits [31:24] the fourth. In a high word, bits [7:0] hold the fifth byte and bits [15:8] the sixth.
- R3: With control bit 0 set, a destination equal to station address A is accepted.
- R4: With control bit 1 set, a destination equal to station address B is accepted; with the bit clear, that address alone does not cause acceptance.
- R5: With control bit 3 set, destination FF:FF:FF:FF:FF:FF is accepted.
- R6: For a group address (first byte bit 0 = 1), the hash index h is the XOR of the eight 6-bit slices of the address, taken LSB-first from first-byte bit 0. The frame is accepted when bit h of the 64-bit table {high word, low word} is set, so indices 0–31 use the low word and 32–63 the high word.
- R7: For an individual address (first byte bit 0 = 0), the hash table is consulted only when control bit 2 is set.
- R8: `dec_vld` is high for exactly one cycle, the cycle after the sixth address byte is taken. `dec_accept` is low whenever `dec_vld` is low.
- R9: A configuration write made after the first byte of a frame does not affect that frame's decision; it applies from the next start of frame.
- R10: Bytes taken after the sixth, or before any start of frame, are ignored. A start-of-frame strobe in the middle of an address restarts the address from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (see R2) |
| cfg_wdata | input | 32 | Configuration write data |
| rx_sof | input | 1 | Marks the byte on `rx_byte` as the first byte of a frame |
| rx_vld | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| dec_vld | output | 1 | Decision strobe, one cycle after the sixth byte |
| dec_accept | output | 1 | 1 = keep frame, valid with `dec_vld` |

## Verification
Some properties are checked by assertions on every cycle:
- the decision strobe lasts a single cycle and always follows a taken byte;
- the acceptance flag is never raised without the strobe;
- the byte counter stays within the address length;
- the working configuration holds still between frame starts.

Other behaviour can only be shown by the bench scenarios. This covers the accept/drop outcome for each combination of control bits against station, broadcast, group and individual addresses. It also covers the mapping of each of the 64 hash indices to its table bit, deferral of mid-frame writes, and restart on an early start strobe.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HTAB_W     = 64;
  localparam int HIDX_W     = $clog2(HTAB_W);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CTRL_W     = 4;
  localparam int WORD_W     = 32;

  localparam int CB_STA_A = 0;
  localparam int CB_STA_B = 1;
  localparam int CB_IHASH = 2;
  localparam int CB_BCAST = 3;

  typedef enum logic [2:0] {
    SEL_A_LO  = 3'd0,
    SEL_A_HI  = 3'd1,
    SEL_B_LO  = 3'd2,
    SEL_B_HI  = 3'd3,
    SEL_HT_LO = 3'd4,
    SEL_HT_HI = 3'd5,
    SEL_CTRL  = 3'd6
  } sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] sta_a;
    logic [ADDR_W-1:0] sta_b;
    logic [HTAB_W-1:0] htab;
    logic [CTRL_W-1:0] ctrl;
  } cfg_t;
endpackage

// File: rtl/rx_da_cfg.sv
module rx_da_cfg
  import rx_da_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              load,
  output cfg_t              cfg_eff
);
  cfg_t shadow_q, shadow_nxt;
  cfg_t active_q, active_nxt;

  always_comb begin
    shadow_nxt = shadow_q;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_A_LO:  shadow_nxt.sta_a[31:0]          = cfg_wdata;
        SEL_A_HI:  shadow_nxt.sta_a[ADDR_W-1:32]   = cfg_wdata[ADDR_W-33:0];
        SEL_B_LO:  shadow_nxt.sta_b[31:0]          = cfg_wdata;
        SEL_B_HI:  shadow_nxt.sta_b[ADDR_W-1:32]   = cfg_wdata[ADDR_W-33:0];
        SEL_HT_LO: shadow_nxt.htab[31:0]           = cfg_wdata;
        SEL_HT_HI: shadow_nxt.htab[HTAB_W-1:32]    = cfg_wdata;
        SEL_CTRL:  shadow_nxt.ctrl                 = cfg_wdata[CTRL_W-1:0];
        default:   shadow_nxt = shadow_q;
      endcase
    end
  end

  always_comb begin
    active_nxt = active_q;
    if (load) active_nxt = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (cfg_we) shadow_q <= shadow_nxt;
      if (load)   active_q <= active_nxt;
    end
  end

  // the frame's first byte already sees the snapshot being loaded
  assign cfg_eff = load ? shadow_q : active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q)); // R9
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide
  import rx_da_pkg::*;
(
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic              hit_bc,
  input  logic              group,
  input  logic [HIDX_W-1:0] hidx,
  input  cfg_t              cfg,
  output logic              accept
);
  logic use_hash;
  logic hash_hit;

  always_comb begin
    use_hash = group | cfg.ctrl[CB_IHASH];
    hash_hit = use_hash & cfg.htab[hidx];
    accept   = (cfg.ctrl[CB_STA_A] & hit_a)
             | (cfg.ctrl[CB_STA_B] & hit_b)
             | (cfg.ctrl[CB_BCAST] & hit_bc)
             | hash_hit;
  end
endmodule

// File: rtl/rx_da_track.sv
module rx_da_track
  import rx_da_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  cfg_t              cfg,
  output logic              hit_a,
  output logic              hit_b,
  output logic              hit_bc,
  output logic              group,
  output logic [HIDX_W-1:0] hidx,
  input  logic              accept,
  output logic              dec_vld,
  output logic              dec_accept
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt, idx;
  logic              a_q, b_q, bc_q, grp_q;
  logic [HIDX_W-1:0] h_q;
  logic              vld_q, acc_q;
  logic              take, last;

  function automatic logic [7:0] pick(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] k);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (k == CNT_W'(i)) r = a[8*i +: 8];
    return r;
  endfunction

  // byte k bit j is address bit 8k+j, folded onto position (8k+j) mod 6
  function automatic logic [HIDX_W-1:0] fold(input logic [7:0] b, input logic [CNT_W-1:0] k);
    logic [HIDX_W-1:0] r;
    int base;
    r = '0;
    base = (8 * int'(k)) % HIDX_W;
    for (int j = 0; j < 8; j++)
      r[(base + j) % HIDX_W] = r[(base + j) % HIDX_W] ^ b[j];
    return r;
  endfunction

  always_comb begin
    idx     = rx_sof ? '0 : cnt_q;
    take    = rx_vld & (rx_sof | (cnt_q < DONE));
    last    = take & (idx == LAST);
    cnt_nxt = take ? idx + 1'b1 : cnt_q;
    hit_a   = (rx_sof | a_q)  & (rx_byte == pick(cfg.sta_a, idx));
    hit_b   = (rx_sof | b_q)  & (rx_byte == pick(cfg.sta_b, idx));
    hit_bc  = (rx_sof | bc_q) & (rx_byte == 8'hFF);
    group   = rx_sof ? rx_byte[0] : grp_q;
    hidx    = (rx_sof ? '0 : h_q) ^ fold(rx_byte, idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= DONE;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
      h_q   <= '0;
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      if (take) begin
        cnt_q <= cnt_nxt;
        a_q   <= hit_a;
        b_q   <= hit_b;
        bc_q  <= hit_bc;
        grp_q <= group;
        h_q   <= hidx;
      end
      vld_q <= last;
      acc_q <= last & accept;
    end
  end

  assign dec_vld    = vld_q;
  assign dec_accept = acc_q;

  AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE); // R10
  AST_VLD_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld); // R8
  AST_VLD_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_vld) |-> $past(rx_vld)); // R8
  AST_ACC_QUAL:    assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !dec_accept); // R8
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rx_sof,
  input  logic        rx_vld,
  input  logic [7:0]  rx_byte,
  output logic        dec_vld,
  output logic        dec_accept
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cfg_t              cfg_eff;
  logic              hit_a, hit_b, hit_bc, group, accept;
  logic [HIDX_W-1:0] hidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rx_da_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .load      (rx_vld & rx_sof),
    .cfg_eff   (cfg_eff)
  );

  rx_da_track u_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rx_sof     (rx_sof),
    .rx_vld     (rx_vld),
    .rx_byte    (rx_byte),
    .cfg        (cfg_eff),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .hit_bc     (hit_bc),
    .group      (group),
    .hidx       (hidx),
    .accept     (accept),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept)
  );

  rx_da_decide u_decide (
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .hit_bc (hit_bc),
    .group  (group),
    .hidx   (hidx),
    .cfg    (cfg_eff),
    .accept (accept)
  );
endmodule

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rx_sof, rx_vld;
  logic [7:0]  rx_byte;
  logic        dec_vld, dec_accept;

  int n_chk = 0;
  int n_bad = 0;

  logic [47:0] m_a, m_b;
  logic [63:0] m_ht;
  logic [3:0]  m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_da_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_sof(rx_sof), .rx_vld(rx_vld),
    .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_accept(dec_accept)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int n = 0; n < 48; n++) h[n % 6] = h[n % 6] ^ a[n];
    return h;
  endfunction

  function automatic logic model(input logic [47:0] a);
    logic acc = 1'b0;
    if (m_ctrl[0] && a == m_a) acc = 1'b1;
    if (m_ctrl[1] && a == m_b) acc = 1'b1;
    if (m_ctrl[3] && a == 48'hFFFF_FFFF_FFFF) acc = 1'b1;
    if ((a[0] || m_ctrl[2]) && m_ht[hash_of(a)]) acc = 1'b1;
    return acc;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [47:0] a, input logic [47:0] b,
                         input logic [63:0] ht, input logic [3:0] c);
    m_a = a; m_b = b; m_ht = ht; m_ctrl = c;
    wr(3'd0, a[31:0]);  wr(3'd1, {16'h0, a[47:32]});
    wr(3'd2, b[31:0]);  wr(3'd3, {16'h0, b[47:32]});
    wr(3'd4, ht[31:0]); wr(3'd5, ht[63:32]);
    wr(3'd6, {28'h0, c});
  endtask

  // sends one address; optional config write alongside byte 2
  task automatic frame(input logic [47:0] a, input bit mid,
                       input logic [2:0] msel, input logic [31:0] mdat,
                       input string req, input logic exp);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0) check({req, " no early strobe"}, dec_vld, 0);
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
      cfg_we = mid && (i == 2); cfg_sel = msel; cfg_wdata = mdat;
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
    check({req, " strobe"}, dec_vld, 1);
    check({req, " accept"}, dec_accept, exp);
    @(negedge clk);
    check("R8 strobe drops", dec_vld, 0);
    check("R8 accept qualified", dec_accept, 0);
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin @(posedge clk); guard++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] ucast, mcast, ad;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rx_sof = 0; rx_vld = 0; rx_byte = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 dec_vld reset", dec_vld, 0);
    check("R1 dec_accept reset", dec_accept, 0);
    m_a = 0; m_b = 0; m_ht = 0; m_ctrl = 0;
    frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R1 bcast dropped", 0);
    frame(48'h0, 0, 0, 0, "R1 zero addr dropped", 0);

    // R2..R7 control sweep over address classes
    ucast = 48'h0A0B_0C0D_0E10;
    mcast = 48'h0000_5E00_0133;
    for (int c = 0; c < 16; c++) begin
      set_cfg(48'h6655_4433_2210, 48'hAB89_6745_2302,
              (64'h1 << hash_of(mcast)) | (64'h1 << hash_of(ucast)), c[3:0]);
      frame(m_a, 0, 0, 0, "R3 R2 station A", model(m_a));
      frame(m_b, 0, 0, 0, "R4 station B", model(m_b));
      frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R5 broadcast", model(48'hFFFF_FFFF_FFFF));
      frame(mcast, 0, 0, 0, "R6 group hash", model(mcast));
      frame(ucast, 0, 0, 0, "R7 individual hash", model(ucast));
    end

    // R6 every hash index against a one-hot table
    for (int k = 0; k < 64; k++) begin
      set_cfg(48'h0, 48'h0, 64'h1 << k, 4'h0);
      ad = {40'h0, 2'b00, k[5:0]} << 1 | 48'h1;
      ad = ad ^ {k[7:0], 40'h0};
      frame(ad, 0, 0, 0, "R6 index sweep", hash_of(ad) == k[5:0]);
      frame(ad, 0, 0, 0, "R6 repeat", model(ad));
    end

    // R9 mid-frame write deferred
    set_cfg(48'h0, 48'h0, 64'h0, 4'h0);
    frame(48'hFFFF_FFFF_FFFF, 1, 3'd6, 32'h8, "R9 write held off", 0);
    m_ctrl = 4'h8;
    frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R9 write applied", 1);

    // R10 trailing bytes ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
      if (i > 0) check("R10 no strobe on payload", dec_vld, 0);
    end
    @(negedge clk); rx_vld = 1'b0;
    check("R10 no strobe on payload", dec_vld, 0);

    // R10 restart on early start strobe
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'hFF;
    end
    frame(48'h1234_5678_9A10, 0, 0, 0, "R10 restart drops", 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'h10;
    end
    frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R10 restart accepts", 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule